// File: doc/BRIEF.md
# Kick-Driven Reset Supervisor

This block is an independent watchdog that sits beside a processor and drives that processor's active-low reset line. A hardware timer feeds it a free-running square wave on the kick input. Every level change of that wave counts as a sign of life. While changes keep arriving inside the timeout window, the reset output stays high. If the wave freezes, for example because the timer that makes it has been stopped, the window runs out. The block then pulls reset low for a fixed minimum time, releases it, and starts a fresh window.

Time is measured in ticks. A prescaler divides the clock by `CLK_HZ / TICK_HZ`. The window length and the pulse width are counts of these ticks. The defaults give a 24 MHz clock, 1 ms ticks, a 120 ms window and a 200 ms pulse, so a kick wave that changes level about every 11 ms never causes a reset. Each accepted kick restarts both the window count and the prescaler phase. As a result, the timeout is an exact number of clock cycles after the kick.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, `wd_rst_n` is low. After `rst_n` is released, `wd_rst_n` stays low for exactly `PULSE_TICKS*DIV` clock cycles and then goes high, where `DIV = CLK_HZ/TICK_HZ`.
- R2: Both a rising and a falling change of `kick_in` count as a kick. The input passes through a two-flop synchroniser, so a kick takes effect on the third rising clock edge after the input changes. Each kick reloads the window to its full length and restarts the prescaler phase.
- R3: Kicks spaced less than `TIMEOUT_TICKS*DIV` cycles apart keep `wd_rst_n` high indefinitely. This covers both fast spacing (about one eleventh of the window) and spacing just under the window.
- R4: If no kick arrives, `wd_rst_n` goes low on the edge exactly `TIMEOUT_TICKS*DIV` cycles after the last kick took effect. It is still high one cycle earlier.
- R5: Once asserted by a timeout, `wd_rst_n` stays low for exactly `PULSE_TICKS*DIV` cycles and then returns high.
- R6: When the pulse ends, a full window of `TIMEOUT_TICKS*DIV` cycles starts, counted from the release edge.
- R7: Kicks that arrive while `wd_rst_n` is low are ignored. They neither shorten the pulse nor extend the window that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CLK_HZ` nominal |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| kick_in | input | 1 | Asynchronous toggling kick signal |
| wd_rst_n | output | 1 | Active-low reset to the supervised processor |

## Verification
The block has only one output, so a bad count or a bad state shows up only as a reset edge that comes too early or too late. For this reason the bench samples the output on the exact cycle of each expected edge and on the cycle before it. A window count that is not reloaded by a kick, or a prescaler that keeps its old phase, moves the timeout edge within one window of the last kick. A pulse counter that a kick can disturb moves the release edge within one pulse width.

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int CLK_HZ        = 24_000_000,
  parameter int TICK_HZ       = 1_000,
  parameter int TIMEOUT_TICKS = 120,
  parameter int PULSE_TICKS   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_in,
  output logic wd_rst_n
);

  localparam int DIV    = CLK_HZ / TICK_HZ;
  localparam int DIV_W  = $clog2(DIV + 1);
  localparam int WIN_W  = $clog2(TIMEOUT_TICKS + 1);
  localparam int PLS_W  = $clog2(PULSE_TICKS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [WIN_W-1:0] WIN_FULL = WIN_W'(TIMEOUT_TICKS);
  localparam logic [PLS_W-1:0] PLS_FULL = PLS_W'(PULSE_TICKS);

  logic             sync1, sync2, sync3;
  logic             hold;
  logic [DIV_W-1:0] div_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic [PLS_W-1:0] pulse_cnt;

  wire kick = sync2 ^ sync3;
  wire tick = (div_cnt == DIV_LAST);

  assign wd_rst_n = ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= kick_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= 1'b1;
      pulse_cnt <= PLS_FULL;
      win_cnt   <= WIN_FULL;
      div_cnt   <= '0;
    end else if (hold) begin
      if (tick) begin
        div_cnt <= '0;
        if (pulse_cnt == PLS_W'(1)) begin
          hold    <= 1'b0;
          win_cnt <= WIN_FULL;
        end else begin
          pulse_cnt <= pulse_cnt - PLS_W'(1);
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end else if (kick) begin
      win_cnt <= WIN_FULL;
      div_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      if (win_cnt == WIN_W'(1)) begin
        hold      <= 1'b1;
        pulse_cnt <= PLS_FULL;
      end else begin
        win_cnt <= win_cnt - WIN_W'(1);
      end
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  AST_KICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (sync2 != sync3)) |=> (win_cnt == WIN_FULL && div_cnt == '0)); // R2

  AST_NO_EARLY_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && win_cnt > WIN_W'(1)) |=> !hold); // R4

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt <= WIN_FULL && pulse_cnt <= PLS_FULL && div_cnt <= DIV_LAST)); // R4

  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> (pulse_cnt == PLS_FULL)); // R5

  AST_WINDOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (win_cnt == WIN_FULL)); // R6

  AST_HOLD_IGNORES_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && pulse_cnt > PLS_W'(1)) |=> hold); // R7

endmodule

// File: tb/test_wdog_supervisor.sv
module test_wdog_supervisor;
  localparam int CLK_HZ = 1_000_000;
  localparam int TICK_HZ = 100_000;
  localparam int TO_T = 12;
  localparam int PL_T = 4;
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int WIN = TO_T * DIV;
  localparam int PLS = PL_T * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick_in = 1'b0;
  logic wd_rst_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_supervisor #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .TIMEOUT_TICKS(TO_T),
                    .PULSE_TICKS(PL_T)) i_wdog_supervisor (
    .clk(clk), .rst_n(rst_n), .kick_in(kick_in), .wd_rst_n(wd_rst_n));

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (wd_rst_n !== exp) begin
      errors++;
      $display("FAIL %s wd_rst_n=%b expected %b at %0t", req, wd_rst_n, exp, $time);
    end
  endtask

  task automatic t_power_on();
    adv(5);
    chk("R1", 1'b0);
    rst_n = 1'b1;
    adv(PLS - 1);
    chk("R1", 1'b0);
    adv(1);
    chk("R1", 1'b1);
  endtask

  task automatic t_freeze_and_pulse();
    kick_in = ~kick_in;
    adv(2 + WIN);
    chk("R4", 1'b1);
    adv(1);
    chk("R4", 1'b0);
    adv(PLS - 1);
    chk("R5", 1'b0);
    adv(1);
    chk("R5", 1'b1);
    adv(WIN - 1);
    chk("R6", 1'b1);
    adv(1);
    chk("R6", 1'b0);
  endtask

  task automatic t_kick_in_hold();
    for (int i = 0; i < 10; i++) begin
      kick_in = ~kick_in;
      adv(3);
    end
    adv(PLS - 31);
    chk("R7", 1'b0);
    adv(1);
    chk("R7", 1'b1);
    adv(WIN - 1);
    chk("R7", 1'b1);
    adv(1);
    chk("R7", 1'b0);
    adv(PLS);
    chk("R5", 1'b1);
  endtask

  task automatic t_both_edges();
    kick_in = 1'b0;
    adv(5);
    kick_in = 1'b1;
    adv(60);
    kick_in = 1'b0;
    adv(2 + WIN);
    chk("R2", 1'b1);
    adv(1);
    chk("R2", 1'b0);
    adv(PLS);
    chk("R2", 1'b1);
  endtask

  task automatic t_periodic(input int gap, input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      kick_in = ~kick_in;
      for (int j = 0; j < gap; j++) begin
        adv(1);
        if (wd_rst_n !== 1'b1) bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s low cycles=%0d expected 0", req, bad);
    end
  endtask

  task automatic t_reassert();
    rst_n = 1'b0;
    adv(1);
    chk("R1", 1'b0);
    rst_n = 1'b1;
    adv(PLS);
    chk("R1", 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_power_on();
    t_freeze_and_pulse();
    t_kick_in_hold();
    t_both_edges();
    t_periodic(11, 60, "R3");
    t_periodic(WIN - 10, 8, "R3");
    t_reassert();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule